// File: doc/BRIEF.md
# Linear Macro-Model Power Estimator

This block produces a per-cycle power figure for a design under test from a set of single-bit activity flags wired out of that design. A static term is added to a weighted sum of the active flags. Each flag has its own programmable weight. The sum is formed in a three-stage pipeline, and each result is pushed into a local trace buffer. The monitored logic never waits on trace storage.

The block is used in three phases. First, the weights and the static term are loaded through a small register-write port while the estimator is idle. Next, `run_en` is held high for the evaluation window, and one estimate is queued for every cycle of that window. After the window closes, the trace buffer is drained through a read port, oldest entry first, into whatever storage follows. A sticky flag reports whether the buffer filled up and estimates were lost.

Top module: `linear_power_estimator`

## Requirements
- R1: After reset the trace buffer is empty, `rd_valid` and `overflow` are low, and every weight and the static term are zero, so a sample taken with all flags active yields 0.
- R2: A sample taken in cycle t equals the static term plus the weights of every flag of `act_in` that is 1 in cycle t, using the coefficient values in force in cycle t. `cfg_addr` 0 holds the 16-bit static term. `cfg_addr` k (1..63) holds the weight of `act_in[k-1]`, taken from the low 12 bits of `cfg_wdata`.
- R3: The result is exact over the whole range: 63 active flags at weight 4095 with a static term of 65535 give 323520.
- R4: Each cycle with `run_en` high produces exactly one buffer entry, in sample order. The entry becomes visible (`fifo_empty` falls) after the third rising edge that follows the sample cycle. A cycle with `run_en` low produces no entry.
- R5: Coefficient writes made while `run_en` is high are ignored. Only the values loaded while idle affect later samples.
- R6: When the buffer already holds 16 entries, further samples are discarded and `overflow` goes high. The first 16 samples are kept. `overflow` stays high until the next cycle in which `run_en` rises, which clears it.
- R7: A read request with the buffer non-empty returns the oldest entry on `rd_data` with `rd_valid` high one cycle later. A request with the buffer empty produces no `rd_valid`.
- R8: While `run_en` is low, neither activity on `act_in` nor read requests add entries: the buffer stays empty and `overflow` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Sampling window enable; also locks the coefficients |
| act_in | input | 63 | Activity flags from the monitored design |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 6 | Coefficient address: 0 is the static term, k is the weight of flag k-1 |
| cfg_wdata | input | 16 | Coefficient write data |
| rd_en | input | 1 | Trace read request |
| rd_data | output | 19 | Trace entry returned by a read |
| rd_valid | output | 1 | `rd_data` holds a returned entry |
| fifo_empty | output | 1 | Trace buffer holds no entries |
| overflow | output | 1 | Sticky: a sample was discarded because the buffer was full |

## Verification
The hardest state to reach is a full buffer while samples are still arriving. In that state the stored entries must stay as the first sixteen, the rest must be dropped, and the sticky flag must survive until the next run starts. To get there, the stimulus runs a window several cycles longer than the buffer depth, lets the pipeline flush, and checks both the flag and the drained contents. It then opens a new single-cycle window to show the flag clears on the rising edge of `run_en`. A second case that is hard to reach is a coefficient write that lands inside a run. The stimulus issues a random write in every cycle of one window, then proves from the drained values that the weights held.

// File: rtl/pe_pkg.sv
package pe_pkg;

  // Width that holds static term plus every weight at full scale, plus margin.
  function automatic int est_width(input int n_act, input int coef_w, input int stat_w);
    int dyn_w;
    dyn_w = coef_w + $clog2(n_act + 1);
    return ((dyn_w > stat_w) ? dyn_w : stat_w) + 1;
  endfunction

endpackage

// File: rtl/pe_coef_bank.sv
module pe_coef_bank #(
  parameter int N_ACT  = 63,
  parameter int COEF_W = 12,
  parameter int STAT_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lock,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [STAT_W-1:0]         wdata,
  output logic [N_ACT*COEF_W-1:0]   weights,
  output logic [STAT_W-1:0]         offset
);

  logic wr_ok;
  assign wr_ok = we && !lock;

  // Static term at address 0.
  logic off_en;
  assign off_en = wr_ok && (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      offset <= '0;
    else if (off_en) offset <= wdata;
  end

  // One weight register per activity flag, at address index+1.
  for (genvar i = 0; i < N_ACT; i++) begin : g_w
    logic              w_en;
    logic [COEF_W-1:0] w_q;
    assign w_en = wr_ok && (addr == ADDR_W'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_en) w_q <= wdata[COEF_W-1:0];
    end
    assign weights[i*COEF_W +: COEF_W] = w_q;
  end

endmodule

// File: rtl/pe_sum_pipe.sv
module pe_sum_pipe #(
  parameter int N_ACT  = 63,
  parameter int COEF_W = 12,
  parameter int STAT_W = 16,
  parameter int GRP    = 8,
  parameter int SUM_W  = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [N_ACT-1:0]        act,
  input  logic [N_ACT*COEF_W-1:0] weights,
  input  logic [STAT_W-1:0]       offset,
  output logic                    out_vld,
  output logic [SUM_W-1:0]        out_sum
);

  localparam int N_GRP  = (N_ACT + GRP - 1) / GRP;
  localparam int N_PAD  = N_GRP * GRP;
  localparam int N_PAIR = (N_GRP + 1) / 2;
  localparam int N_GRP2 = 2 * N_PAIR;
  localparam int G_W    = COEF_W + $clog2(GRP + 1);
  localparam int P_W    = G_W + 1;

  logic [N_PAD-1:0]        act_pad;
  logic [N_PAD*COEF_W-1:0] w_pad;
  assign act_pad = N_PAD'(act);
  assign w_pad   = (N_PAD*COEF_W)'(weights);

  // Stage 1: masked group sums, registered with static term and valid.
  logic [N_GRP2*G_W-1:0] grp_d;
  for (genvar g = 0; g < N_GRP2; g++) begin : g_grp
    if (g < N_GRP) begin : g_real
      logic [G_W-1:0] acc;
      always_comb begin
        acc = '0;
        for (int k = 0; k < GRP; k++) begin
          if (act_pad[g*GRP + k]) acc = acc + G_W'(w_pad[(g*GRP + k)*COEF_W +: COEF_W]);
        end
      end
      assign grp_d[g*G_W +: G_W] = acc;
    end else begin : g_fill
      assign grp_d[g*G_W +: G_W] = '0;
    end
  end

  logic [G_W-1:0]    grp_q [N_GRP2];
  logic [STAT_W-1:0] off_q1;
  logic              vld_q1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q1 <= 1'b0;
    else        vld_q1 <= in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q1 <= '0;
      for (int g = 0; g < N_GRP2; g++) grp_q[g] <= '0;
    end else if (in_vld) begin
      off_q1 <= offset;
      for (int g = 0; g < N_GRP2; g++) grp_q[g] <= grp_d[g*G_W +: G_W];
    end
  end

  // Stage 2: pairwise sums.
  logic [P_W-1:0]    pair_d [N_PAIR];
  logic [P_W-1:0]    pair_q [N_PAIR];
  logic [STAT_W-1:0] off_q2;
  logic              vld_q2;

  always_comb begin
    for (int p = 0; p < N_PAIR; p++)
      pair_d[p] = P_W'(grp_q[2*p]) + P_W'(grp_q[2*p + 1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q2 <= 1'b0;
    else        vld_q2 <= vld_q1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q2 <= '0;
      for (int p = 0; p < N_PAIR; p++) pair_q[p] <= '0;
    end else if (vld_q1) begin
      off_q2 <= off_q1;
      for (int p = 0; p < N_PAIR; p++) pair_q[p] <= pair_d[p];
    end
  end

  // Stage 3: final reduction with static term; stored by the trace buffer.
  always_comb begin
    out_sum = SUM_W'(off_q2);
    for (int p = 0; p < N_PAIR; p++) out_sum = out_sum + SUM_W'(pair_q[p]);
  end
  assign out_vld = vld_q2;

endmodule

// File: rtl/pe_trace_fifo.sv
module pe_trace_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_ovf,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic              ovf
);

  // DEPTH must be a power of two, at least 2.
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W:0] wr_ptr, wr_ptr_d;
  logic [PTR_W:0] rd_ptr, rd_ptr_d;
  logic           full, do_wr, do_rd, ovf_d;
  logic [DATA_W-1:0] mem [DEPTH];

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                 (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
  assign do_wr = wr_vld && !full;
  assign do_rd = rd_en && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr + (do_wr ? 1'b1 : 1'b0);
    rd_ptr_d = rd_ptr + (do_rd ? 1'b1 : 1'b0);
    ovf_d    = (ovf && !clr_ovf) || (wr_vld && full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      ovf      <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      wr_ptr   <= wr_ptr_d;
      rd_ptr   <= rd_ptr_d;
      ovf      <= ovf_d;
      rd_valid <= do_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[PTR_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (do_rd) rd_data <= mem[rd_ptr[PTR_W-1:0]];
  end

endmodule

// File: rtl/linear_power_estimator.sv
module linear_power_estimator #(
  parameter int N_ACT      = 63,
  parameter int COEF_W     = 12,
  parameter int STAT_W     = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int GRP        = 8,
  localparam int ADDR_W    = $clog2(N_ACT + 1),
  localparam int SUM_W     = pe_pkg::est_width(N_ACT, COEF_W, STAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [N_ACT-1:0]  act_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [STAT_W-1:0] cfg_wdata,
  input  logic              rd_en,
  output logic [SUM_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              fifo_empty,
  output logic              overflow
);

  logic [N_ACT*COEF_W-1:0] coef_flat;
  logic [STAT_W-1:0]       offset_q;
  logic                    pipe_vld;
  logic [SUM_W-1:0]        pipe_sum;
  logic                    run_q;
  logic                    run_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end
  assign run_start = run_en && !run_q;

  pe_coef_bank #(
    .N_ACT(N_ACT), .COEF_W(COEF_W), .STAT_W(STAT_W), .ADDR_W(ADDR_W)
  ) u_coef (
    .clk(clk), .rst_n(rst_n), .lock(run_en), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .weights(coef_flat), .offset(offset_q)
  );

  pe_sum_pipe #(
    .N_ACT(N_ACT), .COEF_W(COEF_W), .STAT_W(STAT_W), .GRP(GRP), .SUM_W(SUM_W)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(run_en), .act(act_in),
    .weights(coef_flat), .offset(offset_q), .out_vld(pipe_vld), .out_sum(pipe_sum)
  );

  pe_trace_fifo #(
    .DEPTH(FIFO_DEPTH), .DATA_W(SUM_W)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_vld(pipe_vld), .wr_data(pipe_sum),
    .clr_ovf(run_start), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty(fifo_empty), .ovf(overflow)
  );

endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int WW = 756,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          cfg_we,
  input logic [WW-1:0] weights,
  input logic [SW-1:0] offset,
  input logic          pipe_vld,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          fifo_empty,
  input logic          overflow
);

  // R4: a sample cycle reaches the buffer write two cycles later
  a_r4_sample_reaches_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> ##2 pipe_vld);

  // R4: an idle cycle yields no write
  a_r4_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> ##2 !pipe_vld);

  // R5: coefficients frozen during a run
  a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(weights) && $stable(offset)));

  // R2: coefficients change only on a write strobe
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(weights) && $stable(offset)));

  // R6: overflow sticky while no run starts
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && run_en && $past(run_en)) |=> overflow);

  // R7: returned data only for a request on a non-empty buffer
  a_r7_rd_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en && !fifo_empty));

  // R8: empty buffer stays empty without writes
  a_r8_idle_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !pipe_vld) |=> fifo_empty);

endmodule

bind linear_power_estimator pe_checker #(
  .WW(N_ACT*COEF_W), .SW(STAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
  .weights(coef_flat), .offset(offset_q), .pipe_vld(pipe_vld),
  .rd_en(rd_en), .rd_valid(rd_valid), .fifo_empty(fifo_empty), .overflow(overflow)
);

// File: tb/linear_power_estimator_tb.sv
module linear_power_estimator_tb;

  localparam int N  = 63;
  localparam int D  = 16;
  localparam int SW = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run_en;
  logic [N-1:0]  act_in;
  logic          cfg_we;
  logic [5:0]    cfg_addr;
  logic [15:0]   cfg_wdata;
  logic          rd_en;
  logic [SW-1:0] rd_data;
  logic          rd_valid;
  logic          fifo_empty;
  logic          overflow;

  int n_chk  = 0;
  int n_fail = 0;

  logic [11:0]   m_w [N];
  logic [15:0]   m_off;
  logic [SW-1:0] q [$];
  logic          exp_ovf;
  logic          prev_run;

  always #5 clk = ~clk;

  linear_power_estimator u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .act_in(act_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .fifo_empty(fifo_empty), .overflow(overflow)
  );

  function automatic logic [SW-1:0] est(input logic [N-1:0] a);
    logic [SW-1:0] s;
    s = SW'(m_off);
    for (int i = 0; i < N; i++) if (a[i]) s = s + SW'(m_w[i]);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_coef(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (!run_en) begin
      if (a == 0) m_off = d;
      else        m_w[a-1] = d[11:0];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [N-1:0] rnd_act();
    return N'({$urandom, $urandom});
  endfunction

  // mode 0 random, 1 all ones, 2 random gaps, 3 all zero; noise: cfg writes each cycle
  task automatic run(input int n, input int mode, input bit noise);
    for (int c = 0; c < n; c++) begin
      logic on;
      logic [N-1:0] a;
      @(negedge clk);
      on = (mode == 2) ? 1'($urandom % 2) : 1'b1;
      a  = (mode == 1) ? '1 : (mode == 3) ? '0 : rnd_act();
      run_en = on; act_in = a;
      cfg_we = noise; cfg_addr = 6'($urandom % 64); cfg_wdata = 16'($urandom);
      if (on && !prev_run) exp_ovf = 1'b0;
      if (on) begin
        if (q.size() < D) q.push_back(est(a));
        else exp_ovf = 1'b1;
      end
      prev_run = on;
    end
    @(negedge clk);
    run_en = 1'b0; cfg_we = 1'b0; prev_run = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) begin
      logic [SW-1:0] e;
      e = q.pop_front();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      check(rd_valid == 1'b1 && rd_data == e, req, rd_data, e);
    end
    check(fifo_empty == 1'b1, {req, " empty after drain"}, fifo_empty, 1);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; run_en = 1'b0; act_in = '0; cfg_we = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; rd_en = 1'b0;
    m_off = '0; exp_ovf = 1'b0; prev_run = 1'b0;
    for (int i = 0; i < N; i++) m_w[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
    check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    run(1, 1, 1'b0);
    check(q[0] == 0, "R1 model zero", q[0], 0);
    drain("R1 zero coefficients");

    // R2 random coefficients, upper data bits must be ignored for weights
    wr_coef(6'd0, 16'($urandom));
    for (int i = 1; i <= N; i++) wr_coef(6'(i), 16'($urandom));
    run(10, 0, 1'b0);
    drain("R2 random activity");
    run(3, 3, 1'b0);
    drain("R2 static term only");

    // R4 exact latency of one sample
    @(negedge clk); run_en = 1'b1; act_in = rnd_act(); q.push_back(est(act_in));
    @(negedge clk); run_en = 1'b0;
    @(negedge clk);
    check(fifo_empty == 1'b1, "R4 not yet visible after two edges", fifo_empty, 1);
    @(negedge clk);
    check(fifo_empty == 1'b0, "R4 visible after third edge", fifo_empty, 0);
    drain("R4 single sample");

    // R4 gapped windows
    run(14, 2, 1'b0);
    drain("R4 gapped sampling");

    // R5 writes during a run ignored
    run(12, 0, 1'b1);
    drain("R5 writes during run");
    run(2, 1, 1'b0);
    drain("R5 coefficients kept");

    // R7 read on empty
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(rd_valid == 1'b0, "R7 read on empty", rd_valid, 0);

    // R8 idle activity and reads add nothing
    for (int c = 0; c < 20; c++) begin
      @(negedge clk); act_in = rnd_act(); rd_en = 1'($urandom % 2);
    end
    @(negedge clk); rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check(fifo_empty == 1'b1, "R8 idle empty", fifo_empty, 1);
    check(overflow == 1'b0, "R8 idle overflow", overflow, 0);

    // R3 full-scale
    wr_coef(6'd0, 16'hFFFF);
    for (int i = 1; i <= N; i++) wr_coef(6'(i), 16'h0FFF);
    run(1, 1, 1'b0);
    check(q[0] == 19'd323520, "R3 model full scale", q[0], 323520);
    drain("R3 full scale");

    // R6 overflow, then clear on next run start
    for (int i = 1; i <= N; i++) wr_coef(6'(i), 16'($urandom));
    run(D + 5, 0, 1'b0);
    check(overflow == exp_ovf && exp_ovf, "R6 overflow set", overflow, 1);
    drain("R6 first entries kept");
    check(overflow == 1'b1, "R6 overflow sticky after drain", overflow, 1);
    run(1, 0, 1'b0);
    check(overflow == 1'b0, "R6 overflow cleared by new run", overflow, 0);
    drain("R6 after clear");

    finish_up();
  end

endmodule